// File: doc/BRIEF.md
# Interrupt Response Sequencer

This unit sits beside the instruction decoder of an 8-bit CPU core with a 16-bit address space. It keeps the interrupt state of the core: the response mode, the two enable flags and the table-page register. At every instruction boundary the core pulses `instrDone` and presents the opcode that just finished, its current program counter and its current stack pointer. The sequencer first applies whatever that opcode does to the interrupt state. It then decides whether an interrupt is taken and runs the micro-operations for it: the acknowledge cycle, two stack writes, the vector-table reads and the program counter load.

Return opcodes are carried out here as well. They pop the return address from the stack and load it, and the interrupt decision is made afterwards. If an interrupt is taken at that point, the address it saves is the one just popped. The memory port is abstract and single-cycle: read data is valid in the same cycle as the request. While a sequence runs, `busy` is high. `seqDone` marks its last cycle, and the core resumes from `pcOut` if a load was signalled.

Top module: `intRespSeq`

## Requirements
- R1: After reset the mode is 0, both enable flags are 0, `busy` is low and no memory, load or acknowledge strobe is active.
- R2: Extended opcodes (`instrIsEd`=1) select the response mode. Bytes 0x46 and 0x66 select mode 0, bytes 0x56 and 0x76 select mode 1, and bytes 0x5E and 0x7E select mode 2. The mode is shown on `modeOut`.
- R3: Plain opcode 0xFB sets both enable flags and plain opcode 0xF3 clears both. No maskable request is accepted at the boundary of either opcode, so acceptance is possible only after the instruction that follows an enable.
- R4: While enable flag 1 is clear, a maskable request is ignored: no acknowledge, no memory write and no program counter load.
- R5: An accepted maskable request produces exactly one `intAck` cycle and clears both enable flags.
- R6: Every taken interrupt writes the saved PC high byte at SP-1 and then the low byte at SP-2, in consecutive cycles. It then reports SP-2 on `spOut` together with `spLoad`.
- R7: In mode 1 the service address is 0x0038, whatever the bus byte is.
- R8: Extended opcode 0x47 copies `accIn` into the page register. In mode 2 the table address is {page, bus byte}, with bit 0 kept as read from the bus. The service address takes its low byte from the table address and its high byte from the table address + 1, wrapping at 16 bits.
- R9: In mode 0 a bus byte of the form 11nnn111 gives service address nnn×8. Any other bus byte raises `unsupported` in the acknowledge cycle and leaves out the push and the load.
- R10: A rising edge on `nmiReq` is latched and then served at the next boundary, whatever the enable state and even after 0xFB or 0xF3. It takes priority over a maskable request and produces no acknowledge. It copies flag 1 into flag 2, clears flag 1 and loads 0x0066.
- R11: Plain 0xC9 and extended 0x4D pop the low byte from SP and the high byte from SP+1, load that address and report SP+2, leaving the enable flags unchanged. Extended 0x45 does the same and also copies flag 2 into flag 1.
- R12: After a return, a pending interrupt is evaluated and the address it pushes is the popped address.
- R13: Each `instrDone` accepted while idle leads to exactly one `seqDone` pulse, with `busy` high from the cycle after `instrDone` until `seqDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Instruction boundary strobe |
| instrIsEd | input | 1 | Finished opcode carried the extended prefix |
| instrByte | input | 8 | Opcode byte (after the prefix, if any) |
| accIn | input | 8 | Accumulator value for the page-register load |
| pcIn | input | 16 | Current program counter |
| spIn | input | 16 | Current stack pointer |
| intReq | input | 1 | Maskable request, level |
| nmiReq | input | 1 | Non-maskable request, edge |
| busData | input | 8 | Byte driven by the interrupting device during acknowledge |
| intAck | output | 1 | Acknowledge cycle |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, same cycle |
| pcLoad | output | 1 | Load `pcOut` into the program counter |
| pcOut | output | 16 | New program counter |
| spLoad | output | 1 | Load `spOut` into the stack pointer |
| spOut | output | 16 | New stack pointer |
| busy | output | 1 | Sequence in progress |
| seqDone | output | 1 | Last cycle of a sequence |
| unsupported | output | 1 | Mode-0 bus byte is not a restart opcode |
| iff1Out | output | 1 | Enable flag 1 |
| iff2Out | output | 1 | Enable flag 2 |
| modeOut | output | 2 | Current response mode |

## Verification
Directed sequences cover the ordering corners: enable followed at once by a request, disable with a request present, a request while disabled, an edge request with the flags both clear and both set, and a return followed by an interrupt. Odd vector bytes and the byte 0xFF are used to show that bit 0 is kept and that the second table read crosses into the next page. Mode-0 restart bytes and non-restart bytes separate the served path from the flagged one. Random opcode, request, bus and stack patterns are then checked against a bench model of the flags, mode and page register, so that every combination of mode and enable state reaches the decision logic.

// File: rtl/irqSeqPkg.sv
package irqSeqPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  typedef enum logic [3:0] {
    OP_OTHER, OP_DI, OP_EI, OP_IM0, OP_IM1, OP_IM2, OP_LDI, OP_RET, OP_RETI, OP_RETN
  } opKindT;

  typedef enum logic [3:0] {
    S_IDLE, S_EVAL, S_POPL, S_POPH, S_ACK, S_PUSHH, S_PUSHL, S_VECL, S_VECH, S_LOADPC
  } seqStateT;

  typedef struct packed {
    logic capture;
    logic popLo;
    logic popHi;
    logic takeNmi;
    logic takeInt;
    logic ackLatch;
    logic pushHi;
    logic pushLo;
    logic vecLo;
    logic vecHi;
    logic loadPc;
  } strobeT;

  typedef struct packed {
    logic       retOp;
    logic       blockOp;
    logic       nmiPend;
    logic       iff1;
    logic       isMask;
    logic [1:0] mode;
    logic       busRst;
  } statusT;

  function automatic opKindT decodeOp(input logic isEd, input logic [BYTE_W-1:0] b);
    opKindT k;
    k = OP_OTHER;
    if (!isEd) begin
      case (b)
        8'hF3: k = OP_DI;
        8'hFB: k = OP_EI;
        8'hC9: k = OP_RET;
        default: k = OP_OTHER;
      endcase
    end else begin
      case (b)
        8'h46, 8'h66: k = OP_IM0;
        8'h56, 8'h76: k = OP_IM1;
        8'h5E, 8'h7E: k = OP_IM2;
        8'h47:        k = OP_LDI;
        8'h4D:        k = OP_RETI;
        8'h45:        k = OP_RETN;
        default:      k = OP_OTHER;
      endcase
    end
    return k;
  endfunction
endpackage

// File: rtl/irqSeqDatapath.sv
module irqSeqDatapath
  import irqSeqPkg::*;
#(
  parameter logic [ADDR_W-1:0] NMI_ADDR = 16'h0066,
  parameter logic [ADDR_W-1:0] FIX_ADDR = 16'h0038
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic              instrIsEd,
  input  logic [BYTE_W-1:0] instrByte,
  input  logic [BYTE_W-1:0] accIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic              nmiReq,
  input  logic [BYTE_W-1:0] busData,
  input  logic [BYTE_W-1:0] memRdata,
  output statusT            stat,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic              iff1Out,
  output logic              iff2Out,
  output logic [1:0]        modeOut
);
  localparam logic [ADDR_W-1:0] ONE = 1;

  logic [1:0]        modeR;
  logic              iff1R, iff2R, isMaskR, nmiPrev, nmiPendR;
  logic [BYTE_W-1:0] pageR, vecR;
  logic [ADDR_W-1:0] pcR, spR, tgtR;
  opKindT            opR, opNew;
  logic [ADDR_W-1:0] tblAddr;

  assign opNew   = decodeOp(instrIsEd, instrByte);
  assign tblAddr = {pageR, vecR};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR <= 2'd0; iff1R <= 1'b0; iff2R <= 1'b0; isMaskR <= 1'b0;
      nmiPrev <= 1'b0; nmiPendR <= 1'b0; pageR <= '0; vecR <= '0;
      pcR <= '0; spR <= '0; tgtR <= '0; opR <= OP_OTHER;
    end else begin
      nmiPrev <= nmiReq;
      if (nmiReq && !nmiPrev) nmiPendR <= 1'b1;
      if (stb.capture) begin
        opR <= opNew;
        pcR <= pcIn;
        spR <= spIn;
        case (opNew)
          OP_DI:   begin iff1R <= 1'b0; iff2R <= 1'b0; end
          OP_EI:   begin iff1R <= 1'b1; iff2R <= 1'b1; end
          OP_IM0:  modeR <= 2'd0;
          OP_IM1:  modeR <= 2'd1;
          OP_IM2:  modeR <= 2'd2;
          OP_LDI:  pageR <= accIn;
          OP_RETN: iff1R <= iff2R;
          default: ;
        endcase
      end
      if (stb.popLo) begin tgtR[BYTE_W-1:0] <= memRdata; spR <= spR + ONE; end
      if (stb.popHi) begin tgtR[ADDR_W-1:BYTE_W] <= memRdata; spR <= spR + ONE; end
      if (stb.takeNmi) begin
        iff2R <= iff1R; iff1R <= 1'b0; nmiPendR <= 1'b0;
        tgtR <= NMI_ADDR; isMaskR <= 1'b0;
      end
      if (stb.takeInt) begin iff1R <= 1'b0; iff2R <= 1'b0; isMaskR <= 1'b1; end
      if (stb.ackLatch) begin
        vecR <= busData;
        if (modeR == 2'd1) tgtR <= FIX_ADDR;
        else if (modeR == 2'd0) tgtR <= {{(ADDR_W-6){1'b0}}, busData[5:3], 3'b000};
      end
      if (stb.pushHi || stb.pushLo) spR <= spR - ONE;
      if (stb.vecLo) tgtR[BYTE_W-1:0] <= memRdata;
      if (stb.vecHi) tgtR[ADDR_W-1:BYTE_W] <= memRdata;
      if (stb.loadPc) begin pcR <= tgtR; opR <= OP_OTHER; end
    end
  end

  always_comb begin
    memRd = 1'b0; memWr = 1'b0; memAddr = '0; memWdata = '0;
    if (stb.pushHi) begin
      memWr = 1'b1; memAddr = spR - ONE; memWdata = pcR[ADDR_W-1:BYTE_W];
    end else if (stb.pushLo) begin
      memWr = 1'b1; memAddr = spR - ONE; memWdata = pcR[BYTE_W-1:0];
    end else if (stb.popLo || stb.popHi) begin
      memRd = 1'b1; memAddr = spR;
    end else if (stb.vecLo) begin
      memRd = 1'b1; memAddr = tblAddr;
    end else if (stb.vecHi) begin
      memRd = 1'b1; memAddr = tblAddr + ONE;
    end
  end

  assign stat.retOp   = (opR == OP_RET) || (opR == OP_RETI) || (opR == OP_RETN);
  assign stat.blockOp = (opR == OP_EI) || (opR == OP_DI);
  assign stat.nmiPend = nmiPendR;
  assign stat.iff1    = iff1R;
  assign stat.isMask  = isMaskR;
  assign stat.mode    = modeR;
  assign stat.busRst  = (busData[7:6] == 2'b11) && (busData[2:0] == 3'b111);

  assign pcOut   = tgtR;
  assign spOut   = spR;
  assign iff1Out = iff1R;
  assign iff2Out = iff2R;
  assign modeOut = modeR;
endmodule

// File: rtl/irqSeqCtrl.sv
module irqSeqCtrl
  import irqSeqPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   instrDone,
  input  logic   intReq,
  input  statusT stat,
  output strobeT stb,
  output logic   busy,
  output logic   seqDone,
  output logic   intAck,
  output logic   unsupported
);
  seqStateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb = '0;
    nextState = state;
    intAck = 1'b0;
    unsupported = 1'b0;
    case (state)
      S_IDLE: if (instrDone) begin stb.capture = 1'b1; nextState = S_EVAL; end
      S_EVAL: begin
        if (stat.retOp) nextState = S_POPL;
        else if (stat.nmiPend) begin stb.takeNmi = 1'b1; nextState = S_PUSHH; end
        else if (intReq && stat.iff1 && !stat.blockOp) begin
          stb.takeInt = 1'b1; nextState = S_ACK;
        end else nextState = S_IDLE;
      end
      S_POPL: begin stb.popLo = 1'b1; nextState = S_POPH; end
      S_POPH: begin stb.popHi = 1'b1; nextState = S_LOADPC; end
      S_ACK: begin
        intAck = 1'b1;
        stb.ackLatch = 1'b1;
        if (stat.mode == 2'd0 && !stat.busRst) begin
          unsupported = 1'b1; nextState = S_IDLE;
        end else nextState = S_PUSHH;
      end
      S_PUSHH: begin stb.pushHi = 1'b1; nextState = S_PUSHL; end
      S_PUSHL: begin
        stb.pushLo = 1'b1;
        nextState = (stat.isMask && stat.mode == 2'd2) ? S_VECL : S_LOADPC;
      end
      S_VECL: begin stb.vecLo = 1'b1; nextState = S_VECH; end
      S_VECH: begin stb.vecHi = 1'b1; nextState = S_LOADPC; end
      S_LOADPC: begin stb.loadPc = 1'b1; nextState = stat.retOp ? S_EVAL : S_IDLE; end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign seqDone = (state != S_IDLE) && (nextState == S_IDLE);
endmodule

// File: rtl/intRespSeq.sv
module intRespSeq
  import irqSeqPkg::*;
#(
  parameter logic [15:0] NMI_ADDR = 16'h0066,
  parameter logic [15:0] FIX_ADDR = 16'h0038
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrDone,
  input  logic        instrIsEd,
  input  logic [7:0]  instrByte,
  input  logic [7:0]  accIn,
  input  logic [15:0] pcIn,
  input  logic [15:0] spIn,
  input  logic        intReq,
  input  logic        nmiReq,
  input  logic [7:0]  busData,
  output logic        intAck,
  output logic        memRd,
  output logic        memWr,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  output logic        pcLoad,
  output logic [15:0] pcOut,
  output logic        spLoad,
  output logic [15:0] spOut,
  output logic        busy,
  output logic        seqDone,
  output logic        unsupported,
  output logic        iff1Out,
  output logic        iff2Out,
  output logic [1:0]  modeOut
);
  strobeT stb;
  statusT stat;

  irqSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .intReq(intReq), .stat(stat),
    .stb(stb), .busy(busy), .seqDone(seqDone), .intAck(intAck), .unsupported(unsupported)
  );

  irqSeqDatapath #(.NMI_ADDR(NMI_ADDR), .FIX_ADDR(FIX_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .instrIsEd(instrIsEd), .instrByte(instrByte),
    .accIn(accIn), .pcIn(pcIn), .spIn(spIn), .nmiReq(nmiReq), .busData(busData),
    .memRdata(memRdata), .stat(stat), .memRd(memRd), .memWr(memWr), .memAddr(memAddr),
    .memWdata(memWdata), .pcOut(pcOut), .spOut(spOut), .iff1Out(iff1Out),
    .iff2Out(iff2Out), .modeOut(modeOut)
  );

  assign pcLoad = stb.loadPc;
  assign spLoad = stb.loadPc;
endmodule

// File: rtl/intRespSeqChk.sv
module intRespSeqChk (
  input logic        clk,
  input logic        rstN,
  input logic        instrDone,
  input logic        intAck,
  input logic        iff1Out,
  input logic        memWr,
  input logic [15:0] memAddr,
  input logic        seqDone,
  input logic        busy,
  input logic        pcLoad
);
  // R4
  ack_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> $past(iff1Out));

  // R5
  ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> !iff1Out);

  // R6
  push_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWr) |=> (memWr && memAddr == $past(memAddr) - 16'd1));

  // R13
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  // R13
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && !busy) |=> busy);

  // R13
  load_inside_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> busy);
endmodule

bind intRespSeq intRespSeqChk u_chk (
  .clk(clk), .rstN(rstN), .instrDone(instrDone), .intAck(intAck), .iff1Out(iff1Out),
  .memWr(memWr), .memAddr(memAddr), .seqDone(seqDone), .busy(busy), .pcLoad(pcLoad)
);

// File: tb/test_intRespSeq.sv
module test_intRespSeq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic instrDone = 0, instrIsEd = 0, intReq = 0, nmiReq = 0;
  logic [7:0] instrByte = 0, accIn = 0, busData = 0;
  logic [15:0] pcIn = 0, spIn = 0;
  logic intAck, memRd, memWr, pcLoad, spLoad, busy, seqDone, unsupported, iff1Out, iff2Out;
  logic [15:0] memAddr, pcOut, spOut;
  logic [7:0] memWdata, memRdata;
  logic [1:0] modeOut;

  logic [7:0] mem [0:65535];
  int nChecks = 0, nFails = 0;

  logic [1:0] mMode = 0;
  logic mIff1 = 0, mIff2 = 0;
  logic [7:0] mPage = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intRespSeq i_intRespSeq (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .instrIsEd(instrIsEd),
    .instrByte(instrByte), .accIn(accIn), .pcIn(pcIn), .spIn(spIn), .intReq(intReq),
    .nmiReq(nmiReq), .busData(busData), .intAck(intAck), .memRd(memRd), .memWr(memWr),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .pcLoad(pcLoad),
    .pcOut(pcOut), .spLoad(spLoad), .spOut(spOut), .busy(busy), .seqDone(seqDone),
    .unsupported(unsupported), .iff1Out(iff1Out), .iff2Out(iff2Out), .modeOut(modeOut)
  );

  assign memRdata = mem[memAddr];
  always @(posedge clk) if (memWr) mem[memAddr] <= memWdata;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int kindOf(input bit ed, input logic [7:0] b);
    // 1 DI, 2 EI, 3..5 mode set, 6 page load, 7 plain return, 8 RETN, 0 other
    if (!ed) return (b == 8'hF3) ? 1 : (b == 8'hFB) ? 2 : (b == 8'hC9) ? 7 : 0;
    case (b)
      8'h46, 8'h66: return 3;
      8'h56, 8'h76: return 4;
      8'h5E, 8'h7E: return 5;
      8'h47: return 6;
      8'h4D: return 7;
      8'h45: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic runOp(input bit ed, input logic [7:0] b, input logic [7:0] a,
                       input logic [15:0] pc, input logic [15:0] sp, input bit irq,
                       input bit nmi, input logic [7:0] bus, input string req);
    int k, ackCnt, wrCnt, cyc;
    bit expAck, expUns, doPush, expLoad, gotLoad, uns, done, busySeen;
    logic [15:0] curPc, curSp, tgt, ta, ta1, lastPc, lastSp;
    logic [15:0] wrAddr [2];
    logic [7:0] wrData [2];
    k = kindOf(ed, b);
    curPc = pc; curSp = sp; expAck = 0; expUns = 0; doPush = 0; expLoad = 0; tgt = 0;
    case (k)
      1: begin mIff1 = 0; mIff2 = 0; end
      2: begin mIff1 = 1; mIff2 = 1; end
      3: mMode = 0;
      4: mMode = 1;
      5: mMode = 2;
      6: mPage = a;
      8: mIff1 = mIff2;
      default: ;
    endcase
    if (k == 7 || k == 8) begin
      curPc = {mem[sp + 16'd1], mem[sp]};
      curSp = sp + 16'd2; expLoad = 1;
    end
    if (nmi) begin
      mIff2 = mIff1; mIff1 = 0; tgt = 16'h0066; doPush = 1;
    end else if (irq && mIff1 && k != 1 && k != 2) begin
      mIff1 = 0; mIff2 = 0; expAck = 1;
      if (mMode == 0) begin
        if (bus[7:6] == 2'b11 && bus[2:0] == 3'b111) begin tgt = {10'd0, bus[5:3], 3'd0}; doPush = 1; end
        else expUns = 1;
      end else if (mMode == 1) begin
        tgt = 16'h0038; doPush = 1;
      end else begin
        ta = {mPage, bus}; ta1 = ta + 16'd1;
        tgt = {mem[ta1], mem[ta]}; doPush = 1;
      end
    end
    if (nmi) begin
      @(negedge clk) nmiReq = 1;
      @(negedge clk) nmiReq = 0;
    end
    @(negedge clk);
    instrDone = 1; instrIsEd = ed; instrByte = b; accIn = a; pcIn = pc; spIn = sp;
    intReq = irq; busData = bus;
    @(negedge clk);
    instrDone = 0;
    ackCnt = 0; wrCnt = 0; gotLoad = 0; uns = 0; done = 0; busySeen = busy;
    lastPc = 0; lastSp = 0; wrAddr[0] = 0; wrAddr[1] = 0; wrData[0] = 0; wrData[1] = 0;
    for (cyc = 0; cyc < 40 && !done; cyc++) begin
      if (intAck) ackCnt++;
      if (unsupported) uns = 1;
      if (memWr) begin
        if (wrCnt < 2) begin wrAddr[wrCnt] = memAddr; wrData[wrCnt] = memWdata; end
        wrCnt++;
      end
      if (pcLoad) begin gotLoad = 1; lastPc = pcOut; lastSp = spOut; end
      if (seqDone) done = 1;
      else @(negedge clk);
    end
    intReq = 0;
    chk(done, "R13", "sequence finished", int'(done), 1);
    chk(busySeen, "R13", "busy after boundary", int'(busySeen), 1);
    chk(ackCnt == int'(expAck), "R5", {req, " acknowledge count"}, ackCnt, int'(expAck));
    chk(uns == expUns, "R9", {req, " unsupported flag"}, int'(uns), int'(expUns));
    if (doPush) begin
      curSp = curSp - 16'd2;
      chk(wrCnt == 2, "R6", "push count", wrCnt, 2);
      chk(wrAddr[0] == curSp + 16'd1 && wrData[0] == curPc[15:8], "R6", "high byte push",
          int'({wrAddr[0], wrData[0]}), int'({curSp + 16'd1, curPc[15:8]}));
      chk(wrAddr[1] == curSp && wrData[1] == curPc[7:0], "R6", "low byte push",
          int'({wrAddr[1], wrData[1]}), int'({curSp, curPc[7:0]}));
      curPc = tgt; expLoad = 1;
    end else begin
      chk(wrCnt == 0, "R4", {req, " no stack write"}, wrCnt, 0);
    end
    chk(gotLoad == expLoad, req, "load strobe", int'(gotLoad), int'(expLoad));
    if (expLoad) begin
      chk(lastPc == curPc, req, "new pc", int'(lastPc), int'(curPc));
      chk(lastSp == curSp, "R6", "new sp", int'(lastSp), int'(curSp));
    end
    chk(iff1Out == mIff1 && iff2Out == mIff2, "R3", {req, " enable flags"},
        int'({iff1Out, iff2Out}), int'({mIff1, mIff2}));
    chk(modeOut == mMode, "R2", "mode", int'(modeOut), int'(mMode));
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'(i) ^ 8'h5A;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(modeOut == 0 && !iff1Out && !iff2Out, "R1", "reset flags/mode", int'({modeOut, iff1Out, iff2Out}), 0);
    chk(!busy && !memRd && !memWr && !pcLoad && !intAck && !seqDone, "R1", "reset strobes",
        int'({busy, memRd, memWr, pcLoad, intAck, seqDone}), 0);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !iff1Out, "R1", "idle after reset", int'({busy, iff1Out}), 0);

    mem[16'h2041] = 8'h34; mem[16'h2042] = 8'h12;
    mem[16'h20FF] = 8'h78; mem[16'h2100] = 8'h56; mem[16'h20FE] = 8'h00;
    runOp(1, 8'h5E, 0, 16'h1000, 16'hA000, 0, 0, 0, "R2");
    runOp(1, 8'h47, 8'h20, 16'h1001, 16'hA000, 0, 0, 0, "R8");
    runOp(0, 8'hFB, 0, 16'h1002, 16'hA000, 1, 0, 8'h41, "R3");          // no accept after enable
    runOp(0, 8'h00, 0, 16'h1003, 16'hA000, 1, 0, 8'h41, "R8");          // odd vector
    runOp(0, 8'hFB, 0, 16'h1004, 16'hA000, 0, 0, 0, "R3");
    runOp(0, 8'h00, 0, 16'h1005, 16'hA000, 1, 0, 8'hFF, "R8");          // page wrap
    runOp(0, 8'hFB, 0, 16'h1006, 16'hA000, 0, 0, 0, "R3");
    runOp(0, 8'hF3, 0, 16'h1007, 16'hA000, 1, 0, 8'h41, "R3");          // disable with request
    runOp(0, 8'h00, 0, 16'h1008, 16'hA000, 1, 0, 8'h41, "R4");          // ignored
    runOp(0, 8'h00, 0, 16'h1009, 16'hA000, 0, 1, 0, "R10");             // edge request, flags clear
    runOp(0, 8'hFB, 0, 16'h100A, 16'hA000, 1, 1, 8'h41, "R10");         // edge after enable
    runOp(1, 8'h45, 0, 16'hB000, 16'hA000, 0, 0, 0, "R11");             // restore flag 1
    runOp(0, 8'h00, 0, 16'h100B, 16'hA000, 1, 1, 8'h41, "R10");         // priority over maskable
    runOp(1, 8'h56, 0, 16'h100C, 16'hA000, 0, 0, 0, "R2");
    runOp(0, 8'hFB, 0, 16'h100D, 16'hA000, 0, 0, 0, "R3");
    runOp(0, 8'h00, 0, 16'h100E, 16'hA000, 1, 0, 8'h99, "R7");
    runOp(1, 8'h76, 0, 16'h100F, 16'hA000, 0, 0, 0, "R2");
    runOp(1, 8'h46, 0, 16'h1010, 16'hA000, 0, 0, 0, "R2");
    runOp(0, 8'hFB, 0, 16'h1011, 16'hA000, 0, 0, 0, "R3");
    runOp(0, 8'h00, 0, 16'h1012, 16'hA000, 1, 0, 8'hDF, "R9");          // restart 0x18
    runOp(0, 8'hFB, 0, 16'h1013, 16'hA000, 0, 0, 0, "R3");
    runOp(0, 8'h00, 0, 16'h1014, 16'hA000, 1, 0, 8'h3E, "R9");          // not a restart
    runOp(0, 8'hC9, 0, 16'h1015, 16'hA000, 0, 0, 0, "R11");
    runOp(1, 8'h4D, 0, 16'h1016, 16'hA000, 0, 0, 0, "R11");
    runOp(1, 8'h7E, 0, 16'h1017, 16'hA000, 0, 0, 0, "R2");
    runOp(0, 8'hFB, 0, 16'h1018, 16'hA000, 0, 0, 0, "R3");
    runOp(0, 8'hC9, 0, 16'h1019, 16'hA000, 1, 0, 8'h41, "R12");        // return then interrupt

    for (int n = 0; n < 300; n++) begin
      logic [7:0] ops [13];
      bit eds [13];
      int pick;
      logic [7:0] bus;
      ops = '{8'h00, 8'hF3, 8'hFB, 8'hC9, 8'h46, 8'h66, 8'h56, 8'h76, 8'h5E, 8'h7E, 8'h47, 8'h4D, 8'h45};
      eds = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1};
      pick = int'($urandom % 13);
      bus = ($urandom % 2) ? {2'b11, 3'($urandom), 3'b111} : 8'($urandom);
      runOp(eds[pick], ops[pick], 8'h10 + 8'($urandom % 96), 16'($urandom),
            16'h8000 + 16'($urandom % 16'h7000), bit'($urandom % 2), ($urandom % 8) == 0,
            bus, "R12");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R13 watchdog: actual 0x0 expected 0x1");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule